// File: doc/BRIEF.md
# PCM Frame Serializer and Deserializer

This block moves 16-bit audio samples between a pair of sample FIFOs and a two-wire serial link, one wire for each direction, framed by a frame-sync pulse. It runs in master mode. An external clock generator supplies the bit timing as two single-cycle strobes in the system clock domain. The launch strobe marks the rising bit-clock edge, where output data changes. The capture strobe marks the falling edge, where input data is sampled. The generator also supplies a sync level that is high for one bit period at the start of each frame. The generator and the FIFOs sit outside this block.

At each frame start the transmit side takes one sample from a show-ahead FIFO and shifts it out MSB first. If the FIFO is empty it sends zeros and flags starvation. The receive side assembles 16 bits MSB first and pushes the word with a strobe. Each direction has its own offset control. With the offset set to 1, the MSB follows the sync period by one bit. With the offset set to 0, the MSB shares the bit period of the sync pulse. A global enable gates everything. A separate enable for each direction gates that direction alone.

Top module: `pcm_frame_serdes`

## Requirements
- R1: Each transmitted sample is 16 bits, sent MSB first, one bit per bit period, with `sdo` updated only in the cycle after a launch strobe.
- R2: With `tx_late`=1 the MSB occupies the bit period after the sync period. With `tx_late`=0 it occupies the sync period itself.
- R3: Bits are captured at capture strobes. `rx_late` places the MSB like `tx_late` does, but for the receive side only. One cycle after the capture of the 16th bit, `rxf_push` pulses for one cycle with the word on `rxf_data` (first received bit in bit 15).
- R4: At the launch strobe of the sync period, with transmit active and `txf_empty`=0, `txf_pop` is high in that same cycle, and `txf_data` is the sample sent. There is exactly one pop per frame and no pop at any other time.
- R5: When transmit is active and `txf_empty`=1 at frame start, a 16-bit zero sample is sent, `tx_starve` pulses for one cycle, and nothing is popped.
- R6: In bit periods outside the 16 data bits of a frame, `sdo` is 0. `sdi` is ignored in those periods.
- R7: With `tx_en`=0 there is no pop, no starvation pulse, and `sdo` stays 0, while the receive side still works. With `rx_en`=0 there is no push, while the transmit side still works.
- R8: With `glb_en`=0 neither direction pops, pushes, starves or drives `sdo`, whatever `tx_en` and `rx_en` are.
- R9: `word_done` pulses for one cycle when the last data bit of a transmit sample is launched, and again on each receive push. This gives one pulse for each completed sample in each direction.
- R10: During reset `sdo`, `txf_pop`, `rxf_push`, `tx_starve` and `word_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global transfer enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_late | input | 1 | Transmit MSB one bit after sync when 1, with sync when 0 |
| rx_late | input | 1 | Receive MSB one bit after sync when 1, with sync when 0 |
| bit_launch | input | 1 | Strobe at the rising bit-clock edge (data change) |
| bit_capture | input | 1 | Strobe at the falling bit-clock edge (data sample) |
| sync_bit | input | 1 | High during the sync bit period that opens a frame |
| txf_empty | input | 1 | Transmit FIFO has no sample |
| txf_data | input | 16 | Head sample of the transmit FIFO |
| txf_pop | output | 1 | Consumes the head sample of the transmit FIFO |
| sdo | output | 1 | Serial data out |
| tx_starve | output | 1 | Pulse: frame started with no sample available |
| sdi | input | 1 | Serial data in |
| rxf_data | output | 16 | Received sample |
| rxf_push | output | 1 | Pulse: `rxf_data` holds a new sample |
| word_done | output | 1 | Pulse for each sample completed in either direction |

## Verification
The bench drives frames of 32 bit periods. It changes the two offset controls together and separately, so that a design that shared one offset between directions, or slipped the MSB by one bit, would return every word shifted by one position. Data words with set MSB and LSB bits, and padding periods where `sdi` is held at 1, expose a shift register that is one bit too long or that keeps sampling after the 16th bit, because stray ones then enter the received word or appear on `sdo`. An empty FIFO, a disabled direction and a cleared global enable are each held for whole frames while a sample waits in the FIFO. A design that popped, starved or drove data in those frames would show up in the count of pops, starvation pulses and completion pulses for each frame.

// File: rtl/pcm_fs_pkg.sv
package pcm_fs_pkg;

   // Only legal sample width for this serial format
   localparam int unsigned PCM_SAMPLE_W = 16;

   // Per-direction lane configuration
   typedef struct packed {
      logic active;   // lane may move data this cycle
      logic late;     // MSB one bit period after the sync period
   } lane_cfg_t;

endpackage

// File: rtl/pcm_fs_tx_lane.sv
module pcm_fs_tx_lane
   import pcm_fs_pkg::*;
#(
   parameter int unsigned SAMPLE_W = PCM_SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  lane_cfg_t           cfg,
   input  logic                launch,
   input  logic                frm_start,
   input  logic                fifo_empty,
   input  logic [SAMPLE_W-1:0] fifo_data,
   output logic                fifo_pop,
   output logic                sdo,
   output logic                starve,
   output logic                done
);

   localparam int unsigned CW = $clog2(SAMPLE_W + 1);

   logic [SAMPLE_W-1:0] shreg;
   logic [CW-1:0]       left;
   logic                open_frm;
   logic [SAMPLE_W-1:0] load_word;

   assign open_frm  = cfg.active && launch && frm_start;
   assign fifo_pop  = open_frm && !fifo_empty;
   assign load_word = fifo_empty ? '0 : fifo_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         left   <= '0;
         sdo    <= 1'b0;
         starve <= 1'b0;
         done   <= 1'b0;
      end else begin
         starve <= 1'b0;
         done   <= 1'b0;
         if (!cfg.active) begin
            shreg <= '0;
            left  <= '0;
            sdo   <= 1'b0;
         end else if (open_frm) begin
            starve <= fifo_empty;
            if (cfg.late) begin
               sdo   <= 1'b0;
               shreg <= load_word;
               left  <= CW'(SAMPLE_W);
            end else begin
               sdo   <= load_word[SAMPLE_W-1];
               shreg <= load_word << 1;
               left  <= CW'(SAMPLE_W - 1);
            end
         end else if (launch) begin
            if (left != '0) begin
               sdo   <= shreg[SAMPLE_W-1];
               shreg <= shreg << 1;
               left  <= left - CW'(1);
               done  <= (left == CW'(1));
            end else begin
               sdo <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/pcm_fs_rx_lane.sv
module pcm_fs_rx_lane
   import pcm_fs_pkg::*;
#(
   parameter int unsigned SAMPLE_W = PCM_SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  lane_cfg_t           cfg,
   input  logic                launch,
   input  logic                frm_start,
   input  logic                capture,
   input  logic                sdi,
   output logic [SAMPLE_W-1:0] word,
   output logic                push
);

   localparam int unsigned CW = $clog2(SAMPLE_W + 1);

   logic [SAMPLE_W-1:0] shreg;
   logic [CW-1:0]       left;
   logic                skip;
   logic [SAMPLE_W-1:0] next_sh;

   assign next_sh = {shreg[SAMPLE_W-2:0], sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
         skip  <= 1'b0;
         word  <= '0;
         push  <= 1'b0;
      end else begin
         push <= 1'b0;
         if (!cfg.active) begin
            left <= '0;
            skip <= 1'b0;
         end else if (launch && frm_start) begin
            left <= CW'(SAMPLE_W);
            skip <= cfg.late;
         end else if (capture) begin
            if (skip) begin
               skip <= 1'b0;
            end else if (left != '0) begin
               shreg <= next_sh;
               left  <= left - CW'(1);
               if (left == CW'(1)) begin
                  word <= next_sh;
                  push <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pcm_frame_serdes.sv
module pcm_frame_serdes
   import pcm_fs_pkg::*;
#(
   parameter int unsigned SAMPLE_W = PCM_SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                glb_en,
   input  logic                tx_en,
   input  logic                rx_en,
   input  logic                tx_late,
   input  logic                rx_late,
   input  logic                bit_launch,
   input  logic                bit_capture,
   input  logic                sync_bit,
   input  logic                txf_empty,
   input  logic [SAMPLE_W-1:0] txf_data,
   output logic                txf_pop,
   output logic                sdo,
   output logic                tx_starve,
   input  logic                sdi,
   output logic [SAMPLE_W-1:0] rxf_data,
   output logic                rxf_push,
   output logic                word_done
);

   generate
      if (SAMPLE_W != PCM_SAMPLE_W) begin : g_width_bad
         $error("pcm_frame_serdes: SAMPLE_W must equal 16");
      end
   endgenerate

   lane_cfg_t tx_cfg, rx_cfg;
   logic      tx_done;

   assign tx_cfg = '{active: glb_en && tx_en, late: tx_late};
   assign rx_cfg = '{active: glb_en && rx_en, late: rx_late};

   pcm_fs_tx_lane #(.SAMPLE_W(SAMPLE_W)) tx_lane_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (tx_cfg),
      .launch     (bit_launch),
      .frm_start  (sync_bit),
      .fifo_empty (txf_empty),
      .fifo_data  (txf_data),
      .fifo_pop   (txf_pop),
      .sdo        (sdo),
      .starve     (tx_starve),
      .done       (tx_done)
   );

   pcm_fs_rx_lane #(.SAMPLE_W(SAMPLE_W)) rx_lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (rx_cfg),
      .launch    (bit_launch),
      .frm_start (sync_bit),
      .capture   (bit_capture),
      .sdi       (sdi),
      .word      (rxf_data),
      .push      (rxf_push)
   );

   assign word_done = tx_done || rxf_push;

endmodule

// File: rtl/pcm_frame_serdes_chk.sv
module pcm_frame_serdes_chk #(
   parameter int unsigned SAMPLE_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                glb_en,
   input logic                tx_en,
   input logic                rx_en,
   input logic                bit_launch,
   input logic                bit_capture,
   input logic                sync_bit,
   input logic                txf_empty,
   input logic                txf_pop,
   input logic                sdo,
   input logic                tx_starve,
   input logic                rxf_push,
   input logic [SAMPLE_W-1:0] rxf_data,
   input logic                word_done
);

   // R4
   pop_at_frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txf_pop |-> (bit_launch && sync_bit && !txf_empty));

   // R5
   starve_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_starve |-> $past(txf_empty && bit_launch && sync_bit && glb_en && tx_en));

   // R1
   sdo_moves_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> ($past(bit_launch) || !$past(glb_en && tx_en)));

   // R3
   push_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_push |-> $past(bit_capture && glb_en && rx_en));

   // R7
   tx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(glb_en && tx_en) |=> (!sdo && !tx_starve));

   // R8
   glb_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (!sdo && !rxf_push && !tx_starve && !word_done));

   // R9
   done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> $past(bit_launch || bit_capture));

   // R3
   rx_word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rxf_push |-> $stable(rxf_data));

endmodule

bind pcm_frame_serdes pcm_frame_serdes_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .glb_en      (glb_en),
   .tx_en       (tx_en),
   .rx_en       (rx_en),
   .bit_launch  (bit_launch),
   .bit_capture (bit_capture),
   .sync_bit    (sync_bit),
   .txf_empty   (txf_empty),
   .txf_pop     (txf_pop),
   .sdo         (sdo),
   .tx_starve   (tx_starve),
   .rxf_push    (rxf_push),
   .rxf_data    (rxf_data),
   .word_done   (word_done)
);

// File: tb/pcm_frame_serdes_tb_top.sv
module pcm_frame_serdes_tb_top;

   localparam int W  = 16;
   localparam int FB = 32;   // bit periods per frame
   localparam int PH = 8;    // clock cycles per bit period

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         glb_en = 0, tx_en = 0, rx_en = 0, tx_late = 0, rx_late = 0;
   logic         bit_launch = 0, bit_capture = 0, sync_bit = 0;
   logic         txf_empty = 1'b1;
   logic [W-1:0] txf_data = '0;
   logic         txf_pop, sdo, tx_starve, rxf_push, word_done;
   logic         sdi = 1'b0;
   logic [W-1:0] rxf_data;

   pcm_frame_serdes #(.SAMPLE_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en), .rx_en(rx_en),
      .tx_late(tx_late), .rx_late(rx_late), .bit_launch(bit_launch),
      .bit_capture(bit_capture), .sync_bit(sync_bit), .txf_empty(txf_empty),
      .txf_data(txf_data), .txf_pop(txf_pop), .sdo(sdo), .tx_starve(tx_starve),
      .sdi(sdi), .rxf_data(rxf_data), .rxf_push(rxf_push), .word_done(word_done)
   );

   int errs = 0, checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard and stimulus queues
   logic [W-1:0] txq[$];
   logic [W-1:0] rxq[$];
   logic [W-1:0] exp_tx_q[$];
   logic [W-1:0] exp_rx_q[$];

   task automatic send_tx(input logic [W-1:0] w); txq.push_back(w); endtask
   task automatic send_rx(input logic [W-1:0] w); rxq.push_back(w); endtask

   // pending configuration, applied at the next frame start
   logic c_glb = 0, c_tx = 0, c_rx = 0, c_txl = 0, c_rxl = 0;

   // per-frame state
   bit           run = 0, started = 0;
   int           ph = PH - 1, bc = FB - 1, k;
   bit           f_txact, f_rxact, f_glb;
   int           f_txl, f_rxl;
   logic [W-1:0] f_rxw, acc, w;
   int           pop_cnt, starve_cnt, done_cnt, push_cnt, pad_err;
   bit           exp_pop, exp_starve;
   event         mid_evt;

   always @(negedge clk) begin
      if (run) begin
         // monitor: results of the posedge just passed
         if (txf_pop) begin
            if (txq.size() > 0) void'(txq.pop_front());
            pop_cnt++;
         end
         if (tx_starve) starve_cnt++;
         if (word_done) done_cnt++;
         if (rxf_push) begin
            push_cnt++;
            if (exp_rx_q.size() > 0) begin
               w = exp_rx_q.pop_front();
               chk(rxf_data == w, f_rxl ? "R3" : "R6", "received word", rxf_data, w);
            end else begin
               chk(1'b0, f_glb ? "R7" : "R8", "unexpected push", rxf_data, 0);
            end
         end
         if (started && ph == 4) begin
            k = bc - f_txl;
            if (f_txact && k >= 0 && k < W) begin
               acc = {acc[W-2:0], sdo};
               if (k == W - 1) begin
                  w = exp_tx_q.pop_front();
                  chk(acc == w, f_txl ? "R2" : "R1", "serial word", acc, w);
               end
            end else if (sdo !== 1'b0) begin
               pad_err++;
            end
         end
         if (started && ph == 0 && bc == 20) ->mid_evt;
         if (started && ph == PH - 1 && bc == FB - 1) begin
            chk(pad_err == 0, "R6", "sdo high outside data", pad_err, 0);
            chk(starve_cnt == int'(exp_starve), "R5", "starve pulses", starve_cnt, exp_starve);
            chk(pop_cnt == int'(exp_pop), f_txact ? "R4" : (f_glb ? "R7" : "R8"),
                "pops per frame", pop_cnt, exp_pop);
            chk(push_cnt == int'(f_rxact), f_rxact ? "R3" : (f_glb ? "R7" : "R8"),
                "pushes per frame", push_cnt, f_rxact);
            chk(done_cnt == int'(f_txact) + int'(f_rxact), "R9", "word_done pulses",
                done_cnt, int'(f_txact) + int'(f_rxact));
         end

         // advance bit timing
         if (ph == PH - 1) begin
            ph = 0;
            bc = (bc == FB - 1) ? 0 : bc + 1;
         end else begin
            ph = ph + 1;
         end
         txf_empty = (txq.size() == 0);
         txf_data  = (txq.size() > 0) ? txq[0] : '0;
         if (ph == 0 && bc == 0) begin
            glb_en = c_glb; tx_en = c_tx; rx_en = c_rx; tx_late = c_txl; rx_late = c_rxl;
            f_glb   = c_glb;
            f_txact = c_glb && c_tx;
            f_rxact = c_glb && c_rx;
            f_txl   = int'(c_txl);
            f_rxl   = int'(c_rxl);
            exp_pop    = f_txact && (txq.size() > 0);
            exp_starve = f_txact && (txq.size() == 0);
            if (f_txact) exp_tx_q.push_back(exp_pop ? txq[0] : '0);
            f_rxw = (rxq.size() > 0) ? rxq.pop_front() : 16'hA5C3;
            if (f_rxact) exp_rx_q.push_back(f_rxw);
            pop_cnt = 0; starve_cnt = 0; done_cnt = 0; push_cnt = 0; pad_err = 0;
            acc = '0;
            started = 1;
         end
         bit_launch  = (ph == 0);
         bit_capture = (ph == 4);
         sync_bit    = (bc == 0);
         if (ph == 1) begin
            k = bc - f_rxl;
            sdi = (k >= 0 && k < W) ? f_rxw[W-1-k] : 1'b1;
         end
      end
   end

   task automatic wait_frames(input int n);
      repeat (n) @(mid_evt);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #100000000;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: outputs quiet in reset
      chk(sdo == 0 && txf_pop == 0 && rxf_push == 0, "R10", "reset data outputs",
          {sdo, txf_pop, rxf_push}, 0);
      chk(tx_starve == 0 && word_done == 0, "R10", "reset pulses", {tx_starve, word_done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // mode A both directions
      c_glb = 1; c_tx = 1; c_rx = 1; c_txl = 1; c_rxl = 1;
      send_tx(16'h8001); send_tx(16'hFFFF); send_tx(16'h1234);
      send_rx(16'h8001); send_rx(16'h7FFE); send_rx(16'hBEEF);
      run = 1;
      wait_frames(3);
      // mode B both directions
      c_txl = 0; c_rxl = 0;
      send_tx(16'h0001); send_tx(16'hC3A5); send_tx(16'h8000);
      send_rx(16'h0001); send_rx(16'hFFFF); send_rx(16'h5A5A);
      wait_frames(3);
      // independent offsets
      c_txl = 0; c_rxl = 1;
      send_tx(16'hF00F); send_tx(16'h4321);
      send_rx(16'h8421); send_rx(16'h0F0F);
      wait_frames(2);
      c_txl = 1; c_rxl = 0;
      send_tx(16'h2468); send_tx(16'h8008);
      send_rx(16'hC001); send_rx(16'h1357);
      wait_frames(2);
      // starvation: no transmit samples
      wait_frames(2);
      // transmit disabled with a sample waiting
      c_tx = 0;
      send_tx(16'hDEAD);
      send_rx(16'h9009); send_rx(16'h6006);
      wait_frames(2);
      // global disable
      c_glb = 0; c_tx = 1; c_rx = 1;
      wait_frames(2);
      // re-enable: waiting sample goes out
      c_glb = 1;
      send_rx(16'hCAFE);
      wait_frames(3);
      finish_run();
   end

endmodule